// File: doc/BRIEF.md
# Dual-Port Location Collision Arbiter

This block sits in front of a two-port memory and watches both ports on a single clock. Each port (left and right) presents an enable, a write strobe and an address. When both ports are enabled on the same address, the arbiter hands that location to one port and drives an active-low busy flag toward the other. Ownership goes by order of arrival: the port whose enabled request at that address was already present in the previous cycle keeps the location. A newcomer loses. When both show up in the same cycle, a fixed tie-break picks the left port.

The memory-side outputs are the port requests delayed by one register stage. This lines the write enable up with the registered busy flag, so a losing write is removed before it reaches the array. A mode input selects between two uses. As a master, the arbiter computes busy locally and drives it out. As a slave, the local result is ignored, and busy inputs from a master arbiter gate the writes. Several memories can then act as one wider word.

Top module: `dpca_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, both busy outputs are 1 (released) and both memory write enables are 0.
- R2: Busy stays 1 on both ports unless both enables are 1 and the two addresses are equal in the previous cycle's sampled inputs.
- R3: A port whose enabled request at an address was present in the previous cycle keeps the location when the other port arrives at it; the newcomer's busy output goes to 0 one clock after the collision is sampled.
- R4: When both ports arrive at the same address in the same cycle (neither was enabled at that address the cycle before), the left port wins and the right busy output goes to 0.
- R5: While both ports remain enabled on the same address, the port that won keeps it; the loser's busy stays 0 cycle after cycle.
- R6: Busy returns to 1 one clock after the addresses differ or either port drops its enable.
- R7: In master mode (mode input 1), a port's memory write enable is its write request from the previous cycle (enable and write both 1), forced to 0 while that port's busy output is 0. A blocked write is dropped and never replayed later.
- R8: In slave mode (mode input 0), both busy outputs are held at 1. Each port's memory write enable is its previous-cycle write request gated only by that port's busy input (0 blocks).
- R9: Each memory address output equals that port's address input from the previous cycle.
- R10: The two busy outputs are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| is_master | input | 1 | 1 = compute busy locally, 0 = take busy from inputs |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write strobe (1 = write) |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write strobe (1 = write) |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in_n | input | 1 | Left busy from a master arbiter, active low, slave mode only |
| r_busy_in_n | input | 1 | Right busy from a master arbiter, active low, slave mode only |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_mem_we | output | 1 | Left write enable toward the memory |
| l_mem_addr | output | ADDR_W | Left address toward the memory |
| r_mem_we | output | 1 | Right write enable toward the memory |
| r_mem_addr | output | ADDR_W | Right address toward the memory |

## Verification
Some properties are checked by assertions on every cycle. The two busy flags are never low together. Busy is released after a cycle with no collision. A winner keeps the location while both ports stay put. A same-cycle tie goes left. Master-mode writes are blocked under busy. Slave-mode busy outputs stay quiet. Memory addresses trail the inputs by one cycle.

Other behaviours need the bench's scenarios to show them. These include the arrival order across several cycles, right-port ownership, the write that is dropped and not replayed, and the slave gating. The bench also sweeps every address pair and enable combination of a 3-bit configuration, in both modes.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int NUM_PORTS = 2;
   localparam int P_LEFT    = 0;
   localparam int P_RIGHT   = 1;

endpackage

// File: rtl/dpca_port_track.sv
// Per-port request history: one register stage of enable, write request
// and address. "stay" marks a request already present last cycle.
module dpca_port_track #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output logic              stay,
   output logic              wreq_q,
   output logic [ADDR_W-1:0] addr_q
);

   logic en_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q   <= 1'b0;
         wreq_q <= 1'b0;
         addr_q <= '0;
      end else begin
         en_q   <= en;
         wreq_q <= en & wr;
         addr_q <= addr;
      end
   end

   always_comb begin
      stay = en & en_q & (addr == addr_q);
   end

   // R9: the memory-side address trails the port address by one cycle
   a_r9_addr_delay: assert property (@(posedge clk) disable iff (rst)
      en |=> (addr_q == $past(addr)));

endmodule

// File: rtl/dpca_resolver.sv
// Collision detect, arrival-order ownership and registered busy flags.
module dpca_resolver
   import dpca_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        en,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic [1:0]        stay,
   output logic [1:0]        busy_n
);

   logic   match;
   owner_e owner_q;
   owner_e owner_d;
   owner_e tie_win;

   generate
      if (TIE_LEFT) begin : g_tie_left
         assign tie_win = OWN_LEFT;
      end else begin : g_tie_right
         assign tie_win = OWN_RIGHT;
      end
   endgenerate

   always_comb begin
      match = en[P_LEFT] & en[P_RIGHT] & (addr_l == addr_r);
   end

   always_comb begin
      owner_d = OWN_NONE;
      if (match) begin
         case ({stay[P_RIGHT], stay[P_LEFT]})
            2'b01:   owner_d = OWN_LEFT;
            2'b10:   owner_d = OWN_RIGHT;
            2'b11:   owner_d = (owner_q == OWN_NONE) ? tie_win : owner_q;
            default: owner_d = tie_win;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         owner_q <= OWN_NONE;
         busy_n  <= 2'b11;
      end else begin
         owner_q         <= owner_d;
         busy_n[P_LEFT]  <= (owner_d != OWN_RIGHT);
         busy_n[P_RIGHT] <= (owner_d != OWN_LEFT);
      end
   end

   // R10: at most one port is told it lost
   a_r10_one_loser: assert property (@(posedge clk) disable iff (rst)
      busy_n != 2'b00);

   // R2/R6: no collision sampled means both flags released next cycle
   a_r6_release: assert property (@(posedge clk) disable iff (rst)
      !match |=> (busy_n == 2'b11));

   // R5: a right-port winner keeps the location while both stay
   a_r5_hold_right: assert property (@(posedge clk) disable iff (rst)
      (match && (stay == 2'b11) && !busy_n[P_LEFT]) |=> !busy_n[P_LEFT]);

   // R5: a left-port winner keeps the location while both stay
   a_r5_hold_left: assert property (@(posedge clk) disable iff (rst)
      (match && (stay == 2'b11) && !busy_n[P_RIGHT]) |=> !busy_n[P_RIGHT]);

   // R4: simultaneous arrival goes to the left port
   a_r4_tie_left: assert property (@(posedge clk) disable iff (rst)
      (TIE_LEFT && match && (stay == 2'b00)) |=> (busy_n == 2'b01));

   // R3: a newcomer against an incumbent loses
   a_r3_newcomer_loses: assert property (@(posedge clk) disable iff (rst)
      (match && (stay == 2'b01)) |=> (busy_n == 2'b01));

endmodule

// File: rtl/dpca_wgate.sv
// Chooses the busy source per mode and gates the delayed write requests.
module dpca_wgate
   import dpca_pkg::*;
#(
   parameter int PORTS = NUM_PORTS
) (
   input  logic             is_master,
   input  logic [PORTS-1:0] busy_loc_n,
   input  logic [PORTS-1:0] busy_in_n,
   input  logic [PORTS-1:0] wreq_q,
   output logic [PORTS-1:0] busy_out_n,
   output logic [PORTS-1:0] mem_we
);

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         logic busy_eff_n;
         assign busy_eff_n    = is_master ? busy_loc_n[p] : busy_in_n[p];
         assign busy_out_n[p] = is_master ? busy_loc_n[p] : 1'b1;
         assign mem_we[p]     = wreq_q[p] & busy_eff_n;
      end
   endgenerate

endmodule

// File: rtl/dpca_arbiter.sv
module dpca_arbiter
   import dpca_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              is_master,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_busy_in_n,
   input  logic              r_busy_in_n,
   output logic              l_busy_n,
   output logic              r_busy_n,
   output logic              l_mem_we,
   output logic [ADDR_W-1:0] l_mem_addr,
   output logic              r_mem_we,
   output logic [ADDR_W-1:0] r_mem_addr
);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
         $error("dpca_arbiter: ADDR_W must be within 1..32");
      end
   endgenerate

   logic [NUM_PORTS-1:0]             en_v;
   logic [NUM_PORTS-1:0]             wr_v;
   logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
   logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_q_v;
   logic [NUM_PORTS-1:0]             stay_v;
   logic [NUM_PORTS-1:0]             wreq_q_v;
   logic [NUM_PORTS-1:0]             busy_loc_n;
   logic [NUM_PORTS-1:0]             busy_out_n;
   logic [NUM_PORTS-1:0]             we_v;

   assign en_v   = {r_en, l_en};
   assign wr_v   = {r_wr, l_wr};
   assign addr_v = {r_addr, l_addr};

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_trk
         dpca_port_track #(.ADDR_W(ADDR_W)) trk_i (
            .clk    (clk),
            .rst    (rst),
            .en     (en_v[p]),
            .wr     (wr_v[p]),
            .addr   (addr_v[p]),
            .stay   (stay_v[p]),
            .wreq_q (wreq_q_v[p]),
            .addr_q (addr_q_v[p])
         );
      end
   endgenerate

   dpca_resolver #(.ADDR_W(ADDR_W), .TIE_LEFT(TIE_LEFT)) res_i (
      .clk    (clk),
      .rst    (rst),
      .en     (en_v),
      .addr_l (addr_v[P_LEFT]),
      .addr_r (addr_v[P_RIGHT]),
      .stay   (stay_v),
      .busy_n (busy_loc_n)
   );

   dpca_wgate #(.PORTS(NUM_PORTS)) wg_i (
      .is_master  (is_master),
      .busy_loc_n (busy_loc_n),
      .busy_in_n  ({r_busy_in_n, l_busy_in_n}),
      .wreq_q     (wreq_q_v),
      .busy_out_n (busy_out_n),
      .mem_we     (we_v)
   );

   assign l_busy_n   = busy_out_n[P_LEFT];
   assign r_busy_n   = busy_out_n[P_RIGHT];
   assign l_mem_we   = we_v[P_LEFT];
   assign r_mem_we   = we_v[P_RIGHT];
   assign l_mem_addr = addr_q_v[P_LEFT];
   assign r_mem_addr = addr_q_v[P_RIGHT];

   // R7: in master mode a flagged port never writes
   a_r7_block_left: assert property (@(posedge clk) disable iff (rst)
      (is_master && !l_busy_n) |-> !l_mem_we);
   a_r7_block_right: assert property (@(posedge clk) disable iff (rst)
      (is_master && !r_busy_n) |-> !r_mem_we);

   // R8: slave mode keeps its own busy outputs quiet
   a_r8_slave_quiet: assert property (@(posedge clk) disable iff (rst)
      !is_master |-> (l_busy_n && r_busy_n));

   // R8: slave write blocked by the incoming busy flag
   a_r8_slave_gate: assert property (@(posedge clk) disable iff (rst)
      (!is_master && !l_busy_in_n) |-> !l_mem_we);

endmodule

// File: tb/dpca_arbiter_tb.sv
module dpca_arbiter_tb_top;

   localparam int AW = 3;
   localparam int NA = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          is_master = 1'b1;
   logic          l_en = 1'b0, l_wr = 1'b0, r_en = 1'b0, r_wr = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
   logic          l_busy_n, r_busy_n, l_mem_we, r_mem_we;
   logic [AW-1:0] l_mem_addr, r_mem_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference history, from the requirements
   bit          m_le = 0, m_re = 0;
   bit [AW-1:0] m_la = '0, m_ra = '0;
   int          m_own = 0; // 0 none, 1 left, 2 right

   always #5 clk = ~clk;

   dpca_arbiter #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst(rst), .is_master(is_master),
      .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
      .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
      .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
      .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
      .l_mem_we(l_mem_we), .l_mem_addr(l_mem_addr),
      .r_mem_we(r_mem_we), .r_mem_addr(r_mem_addr)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input string req, input bit le, input bit lw, input int la,
                       input bit re, input bit rw, input int ra,
                       input bit mst, input bit bil, input bit bir);
      bit match, ls, rs, exp_lb, exp_rb, eff_l, eff_r;
      int w;
      @(negedge clk);
      l_en = le; l_wr = lw; l_addr = AW'(la);
      r_en = re; r_wr = rw; r_addr = AW'(ra);
      is_master = mst; l_busy_in_n = bil; r_busy_in_n = bir;
      match = le && re && (AW'(la) == AW'(ra));
      ls = le && m_le && (AW'(la) == m_la);
      rs = re && m_re && (AW'(ra) == m_ra);
      if (!match) w = 0;
      else if (ls && !rs) w = 1;
      else if (rs && !ls) w = 2;
      else if (ls && rs) w = (m_own != 0) ? m_own : 1;
      else w = 1;
      m_own = w; m_le = le; m_re = re; m_la = AW'(la); m_ra = AW'(ra);
      exp_lb = (w != 2);
      exp_rb = (w != 1);
      eff_l = mst ? exp_lb : bil;
      eff_r = mst ? exp_rb : bir;
      @(posedge clk);
      #1;
      chk(req, "l_busy_n", int'(l_busy_n), mst ? int'(exp_lb) : 1);
      chk(req, "r_busy_n", int'(r_busy_n), mst ? int'(exp_rb) : 1);
      chk(req, "l_mem_we", int'(l_mem_we), int'(le && lw && eff_l));
      chk(req, "r_mem_we", int'(r_mem_we), int'(re && rw && eff_r));
      chk("R9", "l_mem_addr", int'(l_mem_addr), la % NA);
      chk("R9", "r_mem_addr", int'(r_mem_addr), ra % NA);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      l_en = 1'b1; r_en = 1'b1; l_wr = 1'b1; r_wr = 1'b1; l_addr = 3; r_addr = 3;
      repeat (3) @(posedge clk);
      #1;
      // R1: flags released and no writes during reset
      chk("R1", "l_busy_n", int'(l_busy_n), 1);
      chk("R1", "r_busy_n", int'(r_busy_n), 1);
      chk("R1", "l_mem_we", int'(l_mem_we), 0);
      chk("R1", "r_mem_we", int'(r_mem_we), 0);
      @(negedge clk);
      rst = 1'b0; l_en = 1'b0; r_en = 1'b0; l_wr = 1'b0; r_wr = 1'b0;
      @(posedge clk);
      #1;
      chk("R1", "l_mem_we", int'(l_mem_we), 0);
      chk("R1", "r_mem_we", int'(r_mem_we), 0);
      chk("R1", "r_busy_n", int'(r_busy_n), 1);

      // R2 / R4: sweep every address pair and enable pair, fresh arrival each time
      for (int m = 1; m >= 0; m--)
         for (int a = 0; a < NA; a++)
            for (int b = 0; b < NA; b++)
               for (int e = 0; e < 4; e++) begin
                  step("R2", 0, 0, 0, 0, 0, 0, m[0], 1, 1);
                  step("R4", e[0], 1, a, e[1], 1, b, m[0], e[0], e[1]);
               end

      // R3 / R5 / R6: left arrives first, right joins, stays, then moves away
      step("R3", 1, 0, 5, 0, 0, 0, 1, 1, 1);
      step("R3", 1, 0, 5, 1, 1, 5, 1, 1, 1);
      step("R5", 1, 0, 5, 1, 1, 5, 1, 1, 1);
      step("R5", 1, 1, 5, 1, 1, 5, 1, 1, 1);
      step("R6", 1, 0, 5, 1, 1, 6, 1, 1, 1);

      // R3 / R6: right arrives first and wins, left released on right disable
      step("R3", 0, 0, 0, 1, 0, 2, 1, 1, 1);
      step("R3", 1, 1, 2, 1, 0, 2, 1, 1, 1);
      step("R5", 1, 1, 2, 1, 0, 2, 1, 1, 1);
      step("R6", 1, 1, 2, 0, 0, 2, 1, 1, 1);

      // R4: both jump together to a new common address each cycle
      step("R4", 1, 1, 1, 1, 1, 1, 1, 1, 1);
      step("R4", 1, 1, 4, 1, 1, 4, 1, 1, 1);
      step("R4", 1, 1, 7, 1, 1, 7, 1, 1, 1);

      // R7: blocked write is dropped, not replayed after release
      step("R7", 0, 0, 0, 0, 0, 0, 1, 1, 1);
      step("R7", 1, 0, 2, 0, 0, 0, 1, 1, 1);
      step("R7", 1, 0, 2, 1, 1, 2, 1, 1, 1);
      step("R7", 1, 0, 2, 1, 1, 2, 1, 1, 1);
      step("R7", 0, 0, 2, 1, 0, 2, 1, 1, 1);
      step("R7", 0, 0, 2, 0, 0, 2, 1, 1, 1);

      // R8: slave mode ignores local contention, obeys busy inputs
      step("R8", 1, 1, 3, 0, 0, 0, 0, 1, 1);
      step("R8", 1, 1, 3, 1, 1, 3, 0, 1, 1);
      step("R8", 1, 1, 3, 1, 1, 3, 0, 0, 1);
      step("R8", 1, 1, 3, 1, 1, 3, 0, 1, 0);
      step("R8", 1, 1, 6, 1, 1, 1, 0, 0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule